// File: doc/BRIEF.md
# Protected-Rail Overcurrent Fault Latch

This block watches the protected dual supply rails (memory, 3.3 V dual and 5 V dual) for an overcurrent condition and shuts the whole power tree down when one persists. An analog comparator outside the block raises a per-rail flag when a rail has sagged to roughly half of its nominal voltage. A rail whose pass device cannot carry the load ends up in that state. The sequencer reports which rails it currently has switched on. The unprotected AGP and 1.8 V rails are never connected to this block.

Each protected rail has its own qualification timer. It counts clock cycles while the rail is switched on and its low flag is raised, and it restarts from zero as soon as either condition drops. Capacitor inrush and short dips therefore pass without effect. When any timer reaches the trip count, one global fault flag latches. A cause vector records which rails had expired at that instant. The fault turns every output off through the sequencer, and it stays set until the enable pin is taken low and back high, or until the standby supply falls below its undervoltage threshold. All inputs are asynchronous to the block clock and are synchronised first.

Top module: `ocp_fault_latch`

## Requirements
- R1: While and directly after synchronous reset, `fault_o` is 0 and `cause_o` is all zeros.
- R2: If an enabled rail keeps its low flag raised for at least TRIP_CYCLES consecutive synchronised cycles, `fault_o` rises. The rise is visible TRIP_CYCLES+3 clock edges after the flag is first applied at the pins (two synchroniser stages, TRIP_CYCLES counting edges, one latch edge).
- R3: A low flag that lasts fewer than TRIP_CYCLES cycles leaves `fault_o` at 0. The rail recovered before the timer expired.
- R4: A rail whose `rail_on_i` bit is 0 is not monitored. Dropping its enable for even one cycle restarts its timer from zero.
- R5: Bit i of `cause_o` belongs to rail i, the same index as `rail_low_i[i]` and `rail_on_i[i]`. On latching, `cause_o` holds exactly the rails whose timers had expired in that cycle. `cause_o` is non-zero whenever `fault_o` is 1, and all zeros whenever `fault_o` is 0.
- R6: Once set, `fault_o` and `cause_o` hold their values regardless of later rail flags or rail enables, until a clear event occurs.
- R7: `enable_i` seen low for at least one synchronised cycle and then high clears `fault_o` and `cause_o`. An `enable_i` that stays high does not clear them.
- R8: While synchronised `supply_ok_i` is 0, `fault_o` and `cause_o` are forced to zero and all timers are held at zero, so no fault can set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_low_i | input | NUM_RAILS | Per-rail below-half-nominal comparator flag, asynchronous |
| rail_on_i | input | NUM_RAILS | Per-rail switched-on flag from the sequencer |
| enable_i | input | 1 | Chip enable pin, active high; a low-then-high toggle clears the fault |
| supply_ok_i | input | 1 | Standby supply above undervoltage threshold |
| fault_o | output | 1 | Latched global shutdown request |
| cause_o | output | NUM_RAILS | Rails whose timers had expired when the fault latched |

## Verification
The hardest situation to reach from the ports is one where several rails expire in the same cycle while other rails are still counting. Reaching it needs flag pulses whose start times and lengths line up exactly across the synchroniser delay. The bench sweeps every rail mask with pulse lengths one below, at and above the trip count. It then launches rails with unequal lengths from a common start, and rails with staggered starts, so the cause vector must separate expired rails from rails that are still counting. A rail is also disabled for a single cycle partway through a long low pulse, to show that its count restarts.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    // Source of a latch clear in the current cycle; supply loss wins.
    typedef enum logic [1:0] {
        CLR_NONE   = 2'd0,
        CLR_ENABLE = 2'd1,
        CLR_SUPPLY = 2'd2
    } clr_src_e;

    // Bits needed to hold the values 0..limit.
    function automatic int unsigned count_bits(input int unsigned limit);
        int unsigned b;
        b = 1;
        while ((limit >> b) != 0) b++;
        return b;
    endfunction

    // Reset pattern of the synchroniser bank: rail flags low, pins high.
    function automatic logic [63:0] sync_reset_pattern(input int unsigned rails);
        logic [63:0] v;
        v = '0;
        v[2*rails]     = 1'b1;
        v[2*rails + 1] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/ocp_rail_timer.sv
module ocp_rail_timer #(
    parameter int unsigned TRIP_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic low_i,
    input  logic on_i,
    input  logic hold_i,
    output logic expired_o
);
    import ocp_pkg::*;

    localparam int unsigned CW = count_bits(TRIP_CYCLES);
    localparam logic [CW-1:0] LIMIT = CW'(TRIP_CYCLES);

    logic [CW-1:0] cnt;
    logic          active;

    assign active = low_i && on_i && !hold_i;

    // Saturating counter that restarts whenever the rail is not in trouble.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired_o = (cnt == LIMIT);

endmodule

// File: rtl/ocp_clear_ctl.sv
module ocp_clear_ctl (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_s_i,
    input  logic              supply_s_i,
    output ocp_pkg::clr_src_e clr_o
);
    import ocp_pkg::*;

    logic enable_prev;

    // Starts high so a pin that is high out of reset is not a rise.
    always_ff @(posedge clk) begin
        if (rst) enable_prev <= 1'b1;
        else     enable_prev <= enable_s_i;
    end

    always_comb begin
        if (!supply_s_i)                     clr_o = CLR_SUPPLY;
        else if (enable_s_i && !enable_prev) clr_o = CLR_ENABLE;
        else                                 clr_o = CLR_NONE;
    end

endmodule

// File: rtl/ocp_latch_core.sv
module ocp_latch_core #(
    parameter int unsigned NUM_RAILS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RAILS-1:0] expired_i,
    input  ocp_pkg::clr_src_e    clr_i,
    output logic                 fault_o,
    output logic [NUM_RAILS-1:0] cause_o
);
    import ocp_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_o <= 1'b0;
            cause_o <= '0;
        end else if (clr_i != CLR_NONE) begin
            fault_o <= 1'b0;
            cause_o <= '0;
        end else if (!fault_o && (|expired_i)) begin
            fault_o <= 1'b1;
            cause_o <= expired_i;
        end
    end

endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch #(
    parameter int unsigned NUM_RAILS   = 3,
    parameter int unsigned TRIP_CYCLES = 1000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RAILS-1:0] rail_low_i,
    input  logic [NUM_RAILS-1:0] rail_on_i,
    input  logic                 enable_i,
    input  logic                 supply_ok_i,
    output logic                 fault_o,
    output logic [NUM_RAILS-1:0] cause_o
);
    import ocp_pkg::*;

    localparam int unsigned SW = 2*NUM_RAILS + 2;
    localparam logic [63:0] RST_FULL = sync_reset_pattern(NUM_RAILS);
    localparam logic [SW-1:0] SYNC_RST = RST_FULL[SW-1:0];

    logic [SW-1:0]        sync_q;
    logic [NUM_RAILS-1:0] low_s;
    logic [NUM_RAILS-1:0] on_s;
    logic                 enable_s;
    logic                 supply_s;
    logic [NUM_RAILS-1:0] expired;
    logic                 timer_hold;
    clr_src_e             clr_src;

    // All pins share one synchroniser bank so their delays line up.
    ocp_sync #(
        .WIDTH  (SW),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i({supply_ok_i, enable_i, rail_on_i, rail_low_i}),
        .q_o(sync_q)
    );

    assign low_s    = sync_q[NUM_RAILS-1:0];
    assign on_s     = sync_q[2*NUM_RAILS-1:NUM_RAILS];
    assign enable_s = sync_q[2*NUM_RAILS];
    assign supply_s = sync_q[2*NUM_RAILS+1];

    // Timers freeze at zero while latched or while standby is missing.
    assign timer_hold = fault_o || !supply_s;

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
        ocp_rail_timer #(
            .TRIP_CYCLES(TRIP_CYCLES)
        ) u_timer (
            .clk      (clk),
            .rst      (rst),
            .low_i    (low_s[i]),
            .on_i     (on_s[i]),
            .hold_i   (timer_hold),
            .expired_o(expired[i])
        );
    end

    ocp_clear_ctl u_clear (
        .clk       (clk),
        .rst       (rst),
        .enable_s_i(enable_s),
        .supply_s_i(supply_s),
        .clr_o     (clr_src)
    );

    ocp_latch_core #(
        .NUM_RAILS(NUM_RAILS)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .expired_i(expired),
        .clr_i    (clr_src),
        .fault_o  (fault_o),
        .cause_o  (cause_o)
    );

endmodule

// File: rtl/ocp_fault_latch_chk.sv
module ocp_fault_latch_chk #(
    parameter int unsigned NUM_RAILS = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 fault_o,
    input logic [NUM_RAILS-1:0] cause_o,
    input logic [NUM_RAILS-1:0] expired,
    input logic [NUM_RAILS-1:0] on_s,
    input logic                 supply_s,
    input ocp_pkg::clr_src_e    clr_src
);
    import ocp_pkg::*;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!fault_o && cause_o == '0));

    assert_trip_source_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_o) |-> ($past(expired) != '0));

    assert_disabled_rail_R4: assert property (@(posedge clk) disable iff (rst)
        (expired & ~$past(on_s)) == '0);

    assert_cause_set_R5: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (cause_o != '0));

    assert_cause_clear_R5: assert property (@(posedge clk) disable iff (rst)
        !fault_o |-> (cause_o == '0));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (fault_o && clr_src == CLR_NONE) |=> (fault_o && $stable(cause_o)));

    assert_enable_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_src == CLR_ENABLE) |=> !fault_o);

    assert_supply_clear_R8: assert property (@(posedge clk) disable iff (rst)
        !supply_s |=> (!fault_o && cause_o == '0));

endmodule

bind ocp_fault_latch ocp_fault_latch_chk #(
    .NUM_RAILS(NUM_RAILS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .fault_o (fault_o),
    .cause_o (cause_o),
    .expired (expired),
    .on_s    (on_s),
    .supply_s(supply_s),
    .clr_src (clr_src)
);

// File: tb/tb_ocp_fault_latch.sv
module tb_ocp_fault_latch;

    localparam int NR       = 3;
    localparam int TRIP     = 6;
    localparam time CLK_PER = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NR-1:0] rail_low = '0;
    logic [NR-1:0] rail_on  = '0;
    logic          enable_pin = 1'b1;
    logic          supply_ok  = 1'b1;
    logic          fault;
    logic [NR-1:0] cause;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    ocp_fault_latch #(
        .NUM_RAILS  (NR),
        .TRIP_CYCLES(TRIP),
        .SYNC_STAGES(2)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .rail_low_i (rail_low),
        .rail_on_i  (rail_on),
        .enable_i   (enable_pin),
        .supply_ok_i(supply_ok),
        .fault_o    (fault),
        .cause_o    (cause)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_by_enable();
        enable_pin = 1'b0;
        cyc(1);
        enable_pin = 1'b1;
        cyc(5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        chk("R1 fault in reset", int'(fault), 0);
        chk("R1 cause in reset", int'(cause), 0);
        rst = 1'b0;
        cyc(1);
        chk("R1 fault after reset", int'(fault), 0);
        chk("R1 cause after reset", int'(cause), 0);

        // Sweep of rail masks against pulse lengths around the trip count.
        rail_on = '1;
        for (int m = 1; m < (1 << NR); m++) begin
            for (int k = -1; k <= 2; k++) begin
                int len;
                bit trip;
                len  = TRIP + k;
                trip = (len >= TRIP);
                rail_low = NR'(m);
                cyc(len);
                rail_low = '0;
                cyc(6);
                chk(trip ? "R2 sweep fault" : "R3 sweep no fault", int'(fault), int'(trip));
                chk("R5 sweep cause", int'(cause), trip ? m : 0);
                cyc(4);
                chk("R6 sweep hold", int'(fault), int'(trip));
                clear_by_enable();
                chk("R7 sweep cleared", int'(fault), 0);
                chk("R7 sweep cause cleared", int'(cause), 0);
            end
        end

        // Exact latency of the trip.
        rail_low = 3'b010;
        cyc(TRIP + 2);
        chk("R2 not yet at T+2", int'(fault), 0);
        cyc(1);
        chk("R2 set at T+3", int'(fault), 1);
        chk("R5 latency cause", int'(cause), 2);
        rail_low = 3'b111;
        cyc(3 * TRIP);
        chk("R6 cause frozen", int'(cause), 2);
        rail_on = '0;
        cyc(4);
        chk("R6 holds with rails off", int'(fault), 1);
        cyc(10);
        chk("R7 steady enable no clear", int'(fault), 1);
        rail_on = '1;
        rail_low = '0;
        clear_by_enable();
        chk("R7 toggle clears", int'(fault), 0);

        // Unequal lengths from a common start.
        rail_low = 3'b111;
        cyc(TRIP - 1);
        rail_low = 3'b101;
        cyc(1);
        rail_low = 3'b001;
        cyc(4);
        rail_low = '0;
        cyc(6);
        chk("R5 unequal cause", int'(cause), 5);
        clear_by_enable();

        // Staggered starts: the late rail is still counting.
        rail_low = 3'b001;
        cyc(2);
        rail_low = 3'b011;
        cyc(2 * TRIP);
        rail_low = '0;
        cyc(4);
        chk("R5 staggered cause", int'(cause), 1);
        clear_by_enable();

        // Disabled rail is ignored.
        rail_on  = 3'b110;
        rail_low = 3'b001;
        cyc(3 * TRIP);
        chk("R4 disabled rail no fault", int'(fault), 0);
        rail_low = '0;
        rail_on  = '1;
        cyc(4);

        // One-cycle disable inside a long low run restarts the count.
        rail_low = 3'b100;
        cyc(TRIP - 1);
        rail_on = 3'b011;
        cyc(1);
        rail_on = '1;
        cyc(TRIP - 1);
        rail_low = '0;
        cyc(6);
        chk("R4 restart no fault", int'(fault), 0);

        // Supply loss clears a latched fault.
        rail_low = 3'b010;
        cyc(TRIP + 4);
        rail_low = '0;
        chk("R2 trip before supply loss", int'(fault), 1);
        supply_ok = 1'b0;
        cyc(1);
        supply_ok = 1'b1;
        cyc(4);
        chk("R8 supply clears fault", int'(fault), 0);
        chk("R8 supply clears cause", int'(cause), 0);

        // Supply held low blocks any trip.
        supply_ok = 1'b0;
        rail_low  = '1;
        cyc(3 * TRIP);
        chk("R8 no trip without supply", int'(fault), 0);
        rail_low  = '0;
        supply_ok = 1'b1;
        cyc(4);
        chk("R8 still clear after return", int'(fault), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule